// File: doc/BRIEF.md
# Two-Thread Windowed Decode Arbiter

This block sits between two per-thread streaming buffers and a decoder that accepts a single instruction token per clock. Each hardware thread pushes opaque tokens into its own small FIFO. The arbiter grants the decoder to one thread at a time. A grant lasts for a window of consecutive decodes. The window length is taken from the number of tokens the chosen thread holds when the grant is made. The decoder is therefore not forced to swap threads every cycle, and a thread with a deep backlog keeps its decode slot for as long as that backlog lasts.

When a window closes, the other thread gets the next window if it has work. If both threads have work, the grant alternates. If only one has work, that thread may be granted again immediately, so the decoder never idles while any token is waiting. The decoded token leaves through a registered output together with the thread number and a valid flag.

Top module: `dual_thread_decode_arb`

## Requirements
- R1: At most one token is removed from the two buffers per cycle. The selected token appears on `dec_tok`, with `dec_valid` high and `dec_tid` naming its thread (0 or 1), exactly one clock after the cycle in which it was selected.
- R2: While `rst_n` is low and after it rises, `dec_valid` is low, both buffers are empty and both full flags are low. The first grant after reset goes to thread 0 when both threads have a token in the same cycle.
- R3: A window is granted only at a window boundary. Its length equals the owning thread's buffer occupancy at that cycle, which does not count a push made in that same cycle. All tokens of the window come from the owning thread on consecutive cycles.
- R4: Tokens pushed into the owning thread's buffer while its window is open do not lengthen that window.
- R5: At a window boundary, if both buffers hold tokens, the grant goes to the thread that did not own the previous window.
- R6: At a window boundary, if only one buffer holds tokens, that thread is granted, even if it owned the previous window.
- R7: Each buffer holds `DEPTH` tokens in push order. Its full flag is high exactly when it holds `DEPTH` tokens, and a push made while the flag is high is dropped without changing the buffer.
- R8: In every cycle in which either buffer holds a token, one token is decoded (no idle cycles while work is pending).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push0 | input | 1 | Push strobe for thread 0 buffer |
| tok0 | input | TOK_W | Token pushed for thread 0 |
| full0 | output | 1 | Thread 0 buffer holds DEPTH tokens |
| push1 | input | 1 | Push strobe for thread 1 buffer |
| tok1 | input | TOK_W | Token pushed for thread 1 |
| full1 | output | 1 | Thread 1 buffer holds DEPTH tokens |
| dec_valid | output | 1 | A decoded token is presented this cycle |
| dec_tid | output | 1 | Thread that owns the presented token |
| dec_tok | output | TOK_W | Presented token |

## Verification
The assertions check several rules on every cycle: at most one buffer is popped, no empty buffer is popped, no idle cycle occurs while work is pending, an open window never outlasts the owner's remaining tokens, a both-eligible boundary always flips ownership, and a push to a full buffer leaves it unchanged. Only the bench's scenarios can show that the exact token sequence comes out with the right thread tags and ordering. That includes the window lengths produced by overlapping push patterns, the dropped tokens under overload, and the thread-0-first rule after reset.

// File: rtl/dta_pkg.sv
package dta_pkg;
  typedef enum logic {
    THR0 = 1'b0,
    THR1 = 1'b1
  } thr_e;

  localparam int NUM_THR = 2;
endpackage

// File: rtl/dta_fifo.sv
module dta_fifo #(
  parameter  int TOK_W = 16,
  parameter  int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TOK_W-1:0] wdata,
  input  logic             pop,
  output logic [TOK_W-1:0] head,
  output logic [CW-1:0]    cnt,
  output logic             full
);

  logic [TOK_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, wptr_n, rptr, rptr_n;
  logic [CW-1:0]    cnt_n;
  logic             push_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign head    = mem[rptr];

  always_comb begin
    wptr_n = push_ok ? ptr_inc(wptr) : wptr;
    rptr_n = pop     ? ptr_inc(rptr) : rptr;
    unique case ({push_ok, pop})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      cnt  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/dta_win_ctl.sv
module dta_win_ctl
  import dta_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  output logic [1:0]    pop,
  output thr_e          sel
);

  logic          win_act, win_act_n;
  thr_e          owner, owner_n;
  logic [CW-1:0] left, left_n;
  logic          e0, e1, start, go;
  logic [CW-1:0] sel_cnt;

  always_comb begin
    e0    = (cnt0 != '0);
    e1    = (cnt1 != '0);
    start = !win_act && (e0 || e1);
    if (win_act)       sel = owner;
    else if (e0 && e1) sel = (owner == THR0) ? THR1 : THR0;
    else if (e1)       sel = THR1;
    else               sel = THR0;
    sel_cnt = (sel == THR1) ? cnt1 : cnt0;
    go      = win_act ? (sel_cnt != '0) : start;
    pop     = !go ? 2'b00 : ((sel == THR1) ? 2'b10 : 2'b01);

    if (start)   left_n = sel_cnt - 1'b1;
    else if (go) left_n = left - 1'b1;
    else         left_n = '0;
    win_act_n = go && (left_n != '0);
    owner_n   = start ? sel : owner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_act <= 1'b0;
      owner   <= THR1;
      left    <= '0;
    end else begin
      win_act <= win_act_n;
      owner   <= owner_n;
      left    <= left_n;
    end
  end

  // R4
  win_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_act |-> (left <= ((owner == THR1) ? cnt1 : cnt0)));

  // R5
  alt_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_act && e0 && e1) |=> (owner != $past(owner)));

endmodule

// File: rtl/dual_thread_decode_arb.sv
module dual_thread_decode_arb
  import dta_pkg::*;
#(
  parameter  int TOK_W = 16,
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push0,
  input  logic [TOK_W-1:0] tok0,
  output logic             full0,
  input  logic             push1,
  input  logic [TOK_W-1:0] tok1,
  output logic             full1,
  output logic             dec_valid,
  output logic             dec_tid,
  output logic [TOK_W-1:0] dec_tok
);

  logic             push_v [NUM_THR];
  logic [TOK_W-1:0] data_v [NUM_THR];
  logic [TOK_W-1:0] head_v [NUM_THR];
  logic [CW-1:0]    cnt_v  [NUM_THR];
  logic             full_v [NUM_THR];
  logic [1:0]       pop;
  thr_e             sel;
  logic             valid_n, tid_n;
  logic [TOK_W-1:0] tok_n;

  assign push_v[0] = push0;
  assign push_v[1] = push1;
  assign data_v[0] = tok0;
  assign data_v[1] = tok1;
  assign full0     = full_v[0];
  assign full1     = full_v[1];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    dta_fifo #(.TOK_W(TOK_W), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_v[t]),
      .wdata (data_v[t]),
      .pop   (pop[t]),
      .head  (head_v[t]),
      .cnt   (cnt_v[t]),
      .full  (full_v[t])
    );
  end

  dta_win_ctl #(.CW(CW)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt0  (cnt_v[0]),
    .cnt1  (cnt_v[1]),
    .pop   (pop),
    .sel   (sel)
  );

  always_comb begin
    valid_n = |pop;
    tid_n   = (sel == THR1);
    tok_n   = (sel == THR1) ? head_v[1] : head_v[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_tid   <= 1'b0;
      dec_tok   <= '0;
    end else begin
      dec_valid <= valid_n;
      if (valid_n) begin
        dec_tid <= tid_n;
        dec_tok <= tok_n;
      end
    end
  end

  // R1
  one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));

  // R8
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_v[0] != '0) || (cnt_v[1] != '0)) |-> (pop != 2'b00));

  // R1
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop != 2'b00) |=> dec_valid);

  // R1
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop == 2'b00) |=> !dec_valid);

endmodule

// File: tb/tb_dual_thread_decode_arb.sv
module tb_dual_thread_decode_arb;
  localparam int TOK_W = 16;
  localparam int DEPTH = 4;
  localparam int NSCN  = 8;
  // each entry: {thread0 push mask, thread1 push mask}, bit i = push in cycle i
  localparam logic [15:0] PAT [NSCN] = '{
    16'hFF00, 16'h00FF, 16'hFFFF, 16'h0FF0,
    16'hAA55, 16'hF00F, 16'h817E, 16'h33CC
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push0 = 1'b0, push1 = 1'b0;
  logic [TOK_W-1:0] tok0 = '0, tok1 = '0;
  logic full0, full1, dec_valid, dec_tid;
  logic [TOK_W-1:0] dec_tok;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic chk_en = 1'b0;
  logic [14:0] seq = '0;

  always #2.5 clk = ~clk;

  dual_thread_decode_arb #(.TOK_W(TOK_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .push0(push0), .tok0(tok0), .full0(full0),
    .push1(push1), .tok1(tok1), .full1(full1),
    .dec_valid(dec_valid), .dec_tid(dec_tid), .dec_tok(dec_tok)
  );

  // reference model written from the requirements
  logic [TOK_W-1:0] q0 [$];
  logic [TOK_W-1:0] q1 [$];
  logic m_act = 1'b0, m_own = 1'b1;
  int   m_left = 0;
  logic e_valid = 1'b0, e_tid = 1'b0;
  logic [TOK_W-1:0] e_tok = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0.delete(); q1.delete();
      m_act = 1'b0; m_own = 1'b1; m_left = 0;
      e_valid = 1'b0; e_tid = 1'b0; e_tok = '0;
    end else begin
      automatic int s0 = q0.size();
      automatic int s1 = q1.size();
      automatic logic t = 1'b0;
      automatic logic dec = 1'b0;
      if (!m_act) begin
        if (s0 > 0 && s1 > 0) begin t = ~m_own; dec = 1'b1; end
        else if (s0 > 0)      begin t = 1'b0;   dec = 1'b1; end
        else if (s1 > 0)      begin t = 1'b1;   dec = 1'b1; end
        if (dec) begin
          m_own  = t;
          m_left = (t ? s1 : s0) - 1;
        end
      end else begin
        t = m_own; dec = 1'b1; m_left = m_left - 1;
      end
      m_act = dec && (m_left > 0);
      e_valid = dec;
      if (dec) begin
        e_tid = t;
        e_tok = t ? q1.pop_front() : q0.pop_front();
      end
      if (push0 && s0 < DEPTH) q0.push_back(tok0);
      if (push1 && s1 < DEPTH) q1.push_back(tok1);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_en && rst_n) begin
      check("R1 R3 R4 R5 R6 R8 valid", 32'(dec_valid), 32'(e_valid));
      if (e_valid) begin
        check("R1 R5 R6 tid", 32'(dec_tid), 32'(e_tid));
        check("R3 R4 R7 token", 32'(dec_tok), 32'(e_tok));
      end
      check("R7 full0", 32'(full0), 32'(q0.size() == DEPTH));
      check("R7 full1", 32'(full1), 32'(q1.size() == DEPTH));
    end
  end

  initial begin
    while (cyc < 190000) @(negedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic drive(input logic p0, input logic p1);
    @(negedge clk);
    push0 = p0; push1 = p1;
    seq = seq + 1'b1;
    tok0 = {1'b0, seq};
    tok1 = {1'b1, seq};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 valid in reset", 32'(dec_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 valid after reset", 32'(dec_valid), 32'd0);
    check("R2 full0 after reset", 32'(full0), 32'd0);
    check("R2 full1 after reset", 32'(full1), 32'd0);

    // R2/R5 directed: both threads get one token in the same cycle
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    check("R1 no output yet", 32'(dec_valid), 32'd0);
    @(negedge clk);
    check("R2 first valid", 32'(dec_valid), 32'd1);
    check("R2 thread 0 first", 32'(dec_tid), 32'd0);
    @(negedge clk);
    check("R5 alternate valid", 32'(dec_valid), 32'd1);
    check("R5 alternate to thread 1", 32'(dec_tid), 32'd1);
    @(negedge clk);
    check("R8 idle when empty", 32'(dec_valid), 32'd0);

    // vector walk against the reference model
    chk_en = 1'b1;
    for (int s = 0; s < NSCN; s++) begin
      for (int i = 0; i < 8; i++) drive(PAT[s][8+i], PAT[s][i]);
      for (int i = 0; i < 14; i++) drive(1'b0, 1'b0);
    end

    // R7 directed overload: both threads push every cycle until a buffer fills
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    check("R7 overload reached full", 32'(full0 | full1), 32'd1);
    for (int i = 0; i < 16; i++) drive(1'b0, 1'b0);
    check("R8 drained", 32'(dec_valid), 32'd0);

    // R6 directed: only thread 1 has work across consecutive boundaries
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule